// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block drives a serial NOR flash as an SPI master in mode 0, one bit per clock. Each request runs one flash instruction as a single chip-select frame. The frame starts with the one-byte opcode. A fixed table, indexed by opcode, then adds up to three address bytes and up to one dummy byte. Last come the data bytes, sent or received, in the count that the request gives. The SPI clock is made from the system clock. Each half period lasts a fixed number of system clocks, and this number is a parameter.

A request is one `start` pulse with an opcode, a 24-bit address, a byte count and an auto-poll flag. Write data is taken one byte at a time. Each time a byte is taken, `wr_req` pulses and the next byte must then be presented. Read data leaves as single-cycle `rd_valid` strobes. When auto-poll is set on a program or erase opcode, the block then sends status-read frames until bit 0 of the status byte reads 0. Only then does it report completion. An opcode that is not in the table is refused with a one-cycle error flag and causes no bus activity. A program request longer than the page limit is refused in the same way.

Top module: `spi_flash_seq`

## Requirements
- R1: Frame shape follows the opcode. 03h, 0Bh, 02h, 20h and D8h send three address bytes, most significant byte first, right after the opcode. 0Bh then adds one dummy byte. 06h, 04h, 05h, 9Fh, C7h, B9h and ABh send no address and no dummy byte.
- R2: The bus runs in SPI mode 0. `sclk` is low whenever `cs_n` is high. Every byte is sent most significant bit first. `miso` is sampled on the rising edge of `sclk`.
- R3: For 05h, 9Fh, 03h and 0Bh, exactly `nbytes` bytes are received after the header. Each one appears on `rd_data` with a one-cycle `rd_valid` pulse, in the order of the bus.
- R4: For 02h, `nbytes` bytes are sent after the address. Each one is taken from `wr_data` in the cycle before a `wr_req` pulse. During dummy bytes and read-data bytes, `mosi` carries 0.
- R5: An `nbytes` of 0 ends the frame after its header. For opcodes with no data phase (06h, 04h, 20h, D8h, C7h, B9h, ABh), `nbytes` has no effect.
- R6: `cs_n` stays low for the whole frame and covers a whole number of bytes. It rises only after the final falling edge of `sclk`. Between two frames it stays high for at least `GAP_CLKS` clocks.
- R7: An opcode that is not listed in R1 gives a one-cycle `err` pulse in the cycle after `start`. It sends no frame, leaves `busy` low and gives no `done`.
- R8: An 02h request with `nbytes` greater than `MAX_PROG` (256) is refused in the same way as R7. An 02h request with exactly 256 bytes is carried out.
- R9: With `auto_poll` set on 02h, 20h, D8h or C7h, the request frame is followed by frames of the form 05h plus one read byte. These repeat until bit 0 of the status byte is 0, and only bit 0 decides this. Status bytes from these frames do not appear on `rd_valid`.
- R10: `auto_poll` has no effect on any other opcode: exactly one frame is sent.
- R11: `busy` rises in the cycle after an accepted `start`. `done` pulses for one cycle at the same time as `busy` falls. A `start` pulse while `busy` is high is ignored.
- R12: During reset and after it, `cs_n` is high, `sclk` is low, and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| opcode | input | 8 | Flash instruction code |
| addr | input | 24 | Flash byte address |
| nbytes | input | LEN_W | Count of data bytes to send or receive |
| auto_poll | input | 1 | Poll status after program or erase |
| wr_data | input | 8 | Next write byte |
| wr_req | output | 1 | Write byte taken; present the next one |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished |
| err | output | 1 | Request refused |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach is the status-poll loop running several times. The flash has to report write-in-progress for a chosen number of status reads, and the status byte also has other bits set, so the block must test bit 0 alone. The bench's behavioural flash holds its busy bit for a count that each request chooses at random. That count covers zero, one and several repeats. The bench then checks the full byte log on `mosi`, including every status frame. Directed cases add a 256-byte page write, a 257-byte refusal, a request issued while busy, and auto-poll on a read.

// File: rtl/sfs_pkg.sv
// Shared types and the opcode shape table for the flash command sequencer.
// Assumes single-bit SPI; the table is pure combinational decode.
package sfs_pkg;

    typedef enum logic [1:0] {DIR_NONE = 2'd0, DIR_RD = 2'd1, DIR_WR = 2'd2} dir_e;

    typedef struct packed {
        logic known;
        logic addr3;
        logic dummy;
        dir_e dir;
        logic pollable;
    } shape_t;

    typedef enum logic [1:0] {PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA} phase_e;
    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} state_e;

    localparam logic [7:0] OPC_WEN   = 8'h06;
    localparam logic [7:0] OPC_WDIS  = 8'h04;
    localparam logic [7:0] OPC_STAT  = 8'h05;
    localparam logic [7:0] OPC_IDENT = 8'h9F;
    localparam logic [7:0] OPC_RD    = 8'h03;
    localparam logic [7:0] OPC_RDF   = 8'h0B;
    localparam logic [7:0] OPC_PROG  = 8'h02;
    localparam logic [7:0] OPC_ER4K  = 8'h20;
    localparam logic [7:0] OPC_ER64K = 8'hD8;
    localparam logic [7:0] OPC_ERALL = 8'hC7;
    localparam logic [7:0] OPC_SLEEP = 8'hB9;
    localparam logic [7:0] OPC_WAKE  = 8'hAB;

    // Map an opcode to its frame shape; unknown codes return known = 0.
    function automatic shape_t shape_of(input logic [7:0] op);
        shape_t s;
        s = '0;
        case (op)
            OPC_WEN, OPC_WDIS, OPC_SLEEP, OPC_WAKE: s.known = 1'b1;
            OPC_STAT, OPC_IDENT: begin
                s.known = 1'b1;
                s.dir   = DIR_RD;
            end
            OPC_RD: begin
                s.known = 1'b1;
                s.addr3 = 1'b1;
                s.dir   = DIR_RD;
            end
            OPC_RDF: begin
                s.known = 1'b1;
                s.addr3 = 1'b1;
                s.dummy = 1'b1;
                s.dir   = DIR_RD;
            end
            OPC_PROG: begin
                s.known    = 1'b1;
                s.addr3    = 1'b1;
                s.dir      = DIR_WR;
                s.pollable = 1'b1;
            end
            OPC_ER4K, OPC_ER64K: begin
                s.known    = 1'b1;
                s.addr3    = 1'b1;
                s.pollable = 1'b1;
            end
            OPC_ERALL: begin
                s.known    = 1'b1;
                s.pollable = 1'b1;
            end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sfs_decode.sv
// Request decoder: looks up the frame shape of an opcode and decides whether
// the request must be refused (unknown opcode or over-long page program).
// Assumes nbytes is wide enough to hold MAX_PROG + 1.
module sfs_decode
    import sfs_pkg::*;
#(
    parameter int LEN_W    = 9,
    parameter int MAX_PROG = 256
) (
    input  logic [7:0]       op,
    input  logic [LEN_W-1:0] len,
    output shape_t           shape,
    output logic             reject
);

    // Combinational table lookup and refusal rule.
    always_comb begin
        shape  = shape_of(op);
        reject = !shape.known ||
                 ((shape.dir == DIR_WR) && (len > LEN_W'(MAX_PROG)));
    end

endmodule

// File: rtl/sfs_bitshift.sv
// Byte serialiser for SPI mode 0. A load pulse starts one byte; bits leave
// MSB first, miso is sampled on each rising sclk, and byte_done pulses in the
// cycle after the eighth falling edge with the received byte on rx_byte.
// Assumes HALF_CLKS >= 1 system clocks per sclk half period.
module sfs_bitshift #(
    parameter int HALF_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);

    localparam int HCW = $clog2(HALF_CLKS + 1);

    logic [HCW-1:0] hcnt;
    logic [2:0]     bitn;
    logic [7:0]     tx_sr;
    logic [7:0]     rx_sr;
    logic           active;

    assign mosi    = tx_sr[7];
    assign rx_byte = rx_sr;

    // Half-period timer, clock toggling and the two shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt      <= '0;
            bitn      <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            active    <= 1'b0;
            sclk      <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (load) begin
                tx_sr  <= tx_byte;
                bitn   <= '0;
                hcnt   <= '0;
                active <= 1'b1;
                sclk   <= 1'b0;
            end else if (active) begin
                if (hcnt == HCW'(HALF_CLKS - 1)) begin
                    hcnt <= '0;
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        rx_sr <= {rx_sr[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == 3'd7) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bitn  <= bitn + 3'd1;
                            tx_sr <= {tx_sr[6:0], 1'b0};
                        end
                    end
                end else begin
                    hcnt <= hcnt + HCW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sfs_frame_ctrl.sv
// Frame sequencer: walks opcode, address, dummy and data phases byte by byte,
// owns chip select and the inter-frame gap, and runs the status-poll loop.
// Assumes the serialiser reports each byte with a single byte_done pulse and
// that wr_data holds the next write byte whenever a byte may be taken.
module sfs_frame_ctrl
    import sfs_pkg::*;
#(
    parameter int LEN_W    = 9,
    parameter int GAP_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       op,
    input  logic [23:0]      addr,
    input  logic [LEN_W-1:0] len,
    input  logic             auto_poll,
    input  shape_t           shape,
    input  logic             reject,
    input  logic [7:0]       wr_data,
    input  logic             byte_done,
    input  logic [7:0]       rx_byte,
    output logic             load,
    output logic [7:0]       tx_byte,
    output logic             cs_n,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             wr_req
);

    localparam int GCW = $clog2(GAP_CLKS + 1);

    state_e           st;
    phase_e           ph;
    shape_t           sh_r;
    logic [LEN_W-1:0] len_r;
    logic [LEN_W-1:0] left;
    logic [23:0]      addr_r;
    logic             polling;
    logic             need_poll;
    logic [GCW-1:0]   gcnt;

    shape_t           act_sh;
    logic [LEN_W-1:0] act_len;
    logic             has_data;
    logic [7:0]       data_byte;
    logic             to_tail;
    logic             nx_end;
    phase_e           nx_ph;
    logic [7:0]       nx_byte;
    logic [LEN_W-1:0] nx_left;
    logic             nx_take;

    assign busy = (st != ST_IDLE);

    // Effective shape: a poll frame is a status read of one byte.
    always_comb begin
        act_sh    = polling ? shape_of(OPC_STAT) : sh_r;
        act_len   = polling ? LEN_W'(1) : len_r;
        has_data  = (act_sh.dir != DIR_NONE) && (act_len != '0);
        data_byte = (act_sh.dir == DIR_WR) ? wr_data : 8'h00;
    end

    // Choose the byte that follows the one just finished, or end the frame.
    always_comb begin
        nx_end  = 1'b0;
        nx_ph   = ph;
        nx_byte = 8'h00;
        nx_left = left;
        nx_take = 1'b0;
        to_tail = 1'b0;
        case (ph)
            PH_OPC: begin
                if (act_sh.addr3) begin
                    nx_ph   = PH_ADDR;
                    nx_byte = addr_r[23:16];
                    nx_left = LEN_W'(2);
                end else if (act_sh.dummy) begin
                    nx_ph = PH_DUMMY;
                end else begin
                    to_tail = 1'b1;
                end
            end
            PH_ADDR: begin
                if (left == LEN_W'(2)) begin
                    nx_byte = addr_r[15:8];
                    nx_left = LEN_W'(1);
                end else if (left == LEN_W'(1)) begin
                    nx_byte = addr_r[7:0];
                    nx_left = '0;
                end else if (act_sh.dummy) begin
                    nx_ph = PH_DUMMY;
                end else begin
                    to_tail = 1'b1;
                end
            end
            PH_DUMMY: to_tail = 1'b1;
            PH_DATA: begin
                if (left != '0) begin
                    nx_byte = data_byte;
                    nx_left = left - LEN_W'(1);
                    nx_take = (act_sh.dir == DIR_WR);
                end else begin
                    nx_end = 1'b1;
                end
            end
            default: nx_end = 1'b1;
        endcase
        if (to_tail) begin
            if (has_data) begin
                nx_ph   = PH_DATA;
                nx_byte = data_byte;
                nx_left = act_len - LEN_W'(1);
                nx_take = (act_sh.dir == DIR_WR);
            end else begin
                nx_end = 1'b1;
            end
        end
    end

    // Request acceptance, byte sequencing, gap timing and the poll loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ph        <= PH_OPC;
            sh_r      <= '0;
            len_r     <= '0;
            left      <= '0;
            addr_r    <= '0;
            polling   <= 1'b0;
            need_poll <= 1'b0;
            gcnt      <= '0;
            load      <= 1'b0;
            tx_byte   <= '0;
            cs_n      <= 1'b1;
            done      <= 1'b0;
            err       <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            wr_req    <= 1'b0;
        end else begin
            load     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            rd_valid <= 1'b0;
            wr_req   <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (reject) begin
                            err <= 1'b1;
                        end else begin
                            sh_r      <= shape;
                            len_r     <= len;
                            addr_r    <= addr;
                            polling   <= 1'b0;
                            need_poll <= auto_poll && shape.pollable;
                            cs_n      <= 1'b0;
                            load      <= 1'b1;
                            tx_byte   <= op;
                            ph        <= PH_OPC;
                            st        <= ST_XFER;
                        end
                    end
                end
                ST_XFER: begin
                    if (byte_done) begin
                        if ((ph == PH_DATA) && (act_sh.dir == DIR_RD)) begin
                            if (polling) begin
                                need_poll <= rx_byte[0];
                            end else begin
                                rd_valid <= 1'b1;
                                rd_data  <= rx_byte;
                            end
                        end
                        if (nx_end) begin
                            cs_n <= 1'b1;
                            gcnt <= '0;
                            st   <= ST_GAP;
                        end else begin
                            load    <= 1'b1;
                            tx_byte <= nx_byte;
                            ph      <= nx_ph;
                            left    <= nx_left;
                            wr_req  <= nx_take;
                        end
                    end
                end
                ST_GAP: begin
                    if (gcnt == GCW'(GAP_CLKS - 1)) begin
                        if (need_poll) begin
                            polling <= 1'b1;
                            cs_n    <= 1'b0;
                            load    <= 1'b1;
                            tx_byte <= OPC_STAT;
                            ph      <= PH_OPC;
                            st      <= ST_XFER;
                        end else begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end
                    end else begin
                        gcnt <= gcnt + GCW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_flash_seq.sv
// Top of the serial NOR flash command sequencer: decoder, frame controller
// and bit serialiser. One request produces one frame, plus status-poll
// frames when auto-poll applies. Assumes a single flash on the bus.
module spi_flash_seq
    import sfs_pkg::*;
#(
    parameter int CLK_HALF = 2,
    parameter int GAP_CLKS = 4,
    parameter int MAX_PROG = 256,
    parameter int LEN_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [23:0]      addr,
    input  logic [LEN_W-1:0] nbytes,
    input  logic             auto_poll,
    input  logic [7:0]       wr_data,
    output logic             wr_req,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);

    shape_t     dec_shape;
    logic       dec_reject;
    logic       sh_load;
    logic [7:0] sh_tx;
    logic       sh_done;
    logic [7:0] sh_rx;

    sfs_decode #(.LEN_W(LEN_W), .MAX_PROG(MAX_PROG)) u_decode (
        .op     (opcode),
        .len    (nbytes),
        .shape  (dec_shape),
        .reject (dec_reject)
    );

    sfs_frame_ctrl #(.LEN_W(LEN_W), .GAP_CLKS(GAP_CLKS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (opcode),
        .addr      (addr),
        .len       (nbytes),
        .auto_poll (auto_poll),
        .shape     (dec_shape),
        .reject    (dec_reject),
        .wr_data   (wr_data),
        .byte_done (sh_done),
        .rx_byte   (sh_rx),
        .load      (sh_load),
        .tx_byte   (sh_tx),
        .cs_n      (cs_n),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .wr_req    (wr_req)
    );

    sfs_bitshift #(.HALF_CLKS(CLK_HALF)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .tx_byte   (sh_tx),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (sh_done),
        .rx_byte   (sh_rx)
    );

endmodule

// File: rtl/sfs_chk.sv
// Protocol checker for the flash command sequencer, bound to the top module.
// Uses only top-level ports plus its own count of chip-select-high cycles.
module sfs_chk #(
    parameter int GAP_CLKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic rd_valid,
    input logic wr_req,
    input logic sclk,
    input logic cs_n
);

    localparam int HW = $clog2(GAP_CLKS + 2);

    logic [HW-1:0] hi_cnt;

    // Count consecutive cycles with chip select high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               hi_cnt <= HW'(GAP_CLKS);
        else if (!cs_n)           hi_cnt <= '0;
        else if (hi_cnt < HW'(GAP_CLKS)) hi_cnt <= hi_cnt + HW'(1);
    end

    // R2
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2
    clk_edge_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !cs_n);

    // R6
    cs_rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !$past(sclk));

    // R6
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= HW'(GAP_CLKS)));

    // R7
    err_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && !busy && !done));

    // R11
    done_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n));

    // R11
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R3
    rd_strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (busy && !wr_req));

endmodule

bind spi_flash_seq sfs_chk #(.GAP_CLKS(GAP_CLKS)) u_chk (.*);

// File: tb/spi_flash_seq_tb.sv
// Bench for the flash command sequencer: behavioural flash on the SPI pins,
// directed corner cases plus seeded random requests.
module spi_flash_seq_tb;

    localparam int LEN_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [7:0]       opcode = '0;
    logic [23:0]      addr = '0;
    logic [LEN_W-1:0] nbytes = '0;
    logic             auto_poll = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             wr_req, rd_valid, busy, done, err, sclk, cs_n, mosi;
    logic [7:0]       rd_data;
    logic             miso = 1'b0;

    int nvec = 0;
    int nfail = 0;

    spi_flash_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr),
        .nbytes(nbytes), .auto_poll(auto_poll), .wr_data(wr_data), .wr_req(wr_req),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .err(err),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always #2 clk = ~clk;

    // ---------------- behavioural flash ----------------
    logic [7:0] fb [0:511];
    logic [7:0] mlog [0:1023];
    logic [7:0] wbuf [0:511];
    logic [7:0] rbuf [0:511];
    logic [7:0] m_cur = '0;
    int m_bit = 0, tot = 0, frames = 0, misal = 0, rcnt = 0, widx = 0;
    int wip_left = 0, tb_k = 0;
    bit tb_ap = 0;

    function automatic logic [7:0] model_byte(int k);
        logic [7:0] o;
        o = 8'h00;
        if (k >= 1) begin
            case (fb[0])
                8'h05: o = {3'b000, 3'b101, 1'b1, (wip_left > 0)};
                8'h9F: o = (k == 1) ? 8'h20 : (k == 2) ? 8'h71 : (k == 3) ? 8'h14 : 8'h00;
                8'h03: if (k >= 4) o = (fb[3] + 8'(k - 4)) ^ 8'hA5;
                8'h0B: if (k >= 5) o = (fb[3] + 8'(k - 5)) ^ 8'hA5;
                default: o = 8'h00;
            endcase
        end
        return o;
    endfunction

    function automatic logic out_bit();
        logic [7:0] b;
        b = model_byte(m_bit / 8);
        return b[7 - (m_bit % 8)];
    endfunction

    always @(negedge cs_n) if (cs_n === 1'b0) begin
        m_bit = 0;
        frames++;
        miso = out_bit();
    end

    always @(posedge sclk) if (cs_n === 1'b0) begin
        m_cur = {m_cur[6:0], mosi};
        m_bit++;
        if (m_bit % 8 == 0) begin
            fb[m_bit / 8 - 1] = m_cur;
            mlog[tot] = m_cur;
            tot++;
        end
    end

    always @(negedge sclk) if (cs_n === 1'b0) miso = out_bit();

    always @(posedge cs_n) if (m_bit > 0) begin
        if (m_bit % 8 != 0) misal++;
        if (m_bit >= 8) begin
            if (fb[0] == 8'h02 || fb[0] == 8'h20 || fb[0] == 8'hD8 || fb[0] == 8'hC7)
                wip_left = tb_ap ? tb_k : 0;
            else if (fb[0] == 8'h05 && wip_left > 0)
                wip_left--;
        end
        m_bit = 0;
    end

    always @(negedge clk) if (rd_valid === 1'b1) begin
        rbuf[rcnt] = rd_data;
        rcnt++;
    end

    // Present the next write byte after each one is taken.
    initial forever begin
        @(negedge clk);
        if (wr_req === 1'b1) begin
            widx++;
            wr_data = wbuf[widx];
        end
    end

    // ---------------- expected behaviour ----------------
    function automatic void shp(input logic [7:0] op, output bit k, output bit a,
                                output bit d, output bit rd, output bit wr, output bit pl);
        k = 1; a = 0; d = 0; rd = 0; wr = 0; pl = 0;
        case (op)
            8'h06, 8'h04, 8'hB9, 8'hAB: ;
            8'h05, 8'h9F: rd = 1;
            8'h03: begin a = 1; rd = 1; end
            8'h0B: begin a = 1; d = 1; rd = 1; end
            8'h02: begin a = 1; wr = 1; pl = 1; end
            8'h20, 8'hD8: begin a = 1; pl = 1; end
            8'hC7: pl = 1;
            default: k = 0;
        endcase
    endfunction

    function automatic logic [7:0] rd_exp(logic [7:0] op, logic [23:0] a, int i);
        case (op)
            8'h05: return 8'h16;
            8'h9F: return (i == 0) ? 8'h20 : (i == 1) ? 8'h71 : (i == 2) ? 8'h14 : 8'h00;
            default: return (a[7:0] + 8'(i)) ^ 8'hA5;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [23:0] a, input int len,
                          input bit ap, input int k, input bit inject);
        bit kn, ha, hd, rd, wr, pl, rej;
        logic [7:0] e [0:1023];
        int n, nfr, bad, t;
        shp(op, kn, ha, hd, rd, wr, pl);
        rej = !kn || (wr && len > 256);
        for (int i = 0; i < 512; i++) wbuf[i] = 8'($urandom);
        widx = 0; wr_data = wbuf[0];
        tot = 0; frames = 0; rcnt = 0; misal = 0; tb_ap = ap; tb_k = k;
        @(negedge clk);
        opcode = op; addr = a; nbytes = LEN_W'(len); auto_poll = ap; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (rej) begin
            // R7 R8: refused request
            chk(err === 1'b1, (kn ? "R8" : "R7"), "err pulse", err, 1);
            chk(busy === 1'b0, (kn ? "R8" : "R7"), "busy after refusal", busy, 0);
            repeat (8) @(negedge clk);
            chk(frames == 0 && err === 1'b0 && done === 1'b0, (kn ? "R8" : "R7"),
                "frames after refusal", frames, 0);
            return;
        end
        chk(busy === 1'b1 && err === 1'b0, "R11", "busy after start", busy, 1);
        if (inject) begin
            repeat (10) @(negedge clk);
            opcode = 8'h06; start = 1'b1;
            @(negedge clk);
            start = 1'b0; opcode = op;
        end
        t = 0;
        while (done !== 1'b1 && t < 30000) begin
            @(negedge clk);
            t++;
        end
        chk(done === 1'b1 && busy === 1'b0, "R11", "done with busy low", done, 1);
        n = 0;
        e[n++] = op;
        if (ha) begin e[n++] = a[23:16]; e[n++] = a[15:8]; e[n++] = a[7:0]; end
        if (hd) e[n++] = 8'h00;
        if (rd || wr) for (int i = 0; i < len; i++) e[n++] = wr ? wbuf[i] : 8'h00;
        nfr = 1;
        if (pl && ap) for (int j = 0; j <= k; j++) begin e[n++] = 8'h05; e[n++] = 8'h00; nfr++; end
        chk(tot == n, "R1", "mosi byte count", tot, n);
        bad = -1;
        for (int i = 0; i < n && i < tot; i++) if (bad < 0 && mlog[i] !== e[i]) bad = i;
        chk(bad < 0, (wr ? "R4" : "R1"), "mosi byte value", (bad < 0) ? 0 : mlog[bad],
            (bad < 0) ? 0 : e[bad]);
        chk(frames == nfr, (pl ? (ap ? "R9" : "R10") : "R10"), "frame count", frames, nfr);
        chk(misal == 0, "R6", "frame not byte aligned", misal, 0);
        chk(rcnt == (rd ? len : 0), (len == 0 ? "R5" : "R3"), "read byte count", rcnt,
            rd ? len : 0);
        bad = -1;
        for (int i = 0; i < rcnt && rd; i++) if (bad < 0 && rbuf[i] !== rd_exp(op, a, i)) bad = i;
        chk(bad < 0, "R3", "read byte value", (bad < 0) ? 0 : rbuf[bad],
            (bad < 0) ? 0 : rd_exp(op, a, bad));
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    logic [7:0] ops [0:13] = '{8'h06, 8'h04, 8'h05, 8'h9F, 8'h03, 8'h0B, 8'h02,
                               8'h20, 8'hD8, 8'hC7, 8'hB9, 8'hAB, 8'h5A, 8'hFF};

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (5) @(negedge clk);
        // R12: reset state
        chk(cs_n === 1'b1 && sclk === 1'b0, "R12", "bus idle in reset", {cs_n, sclk}, 2);
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R12", "flags in reset",
            {busy, done, err}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && busy === 1'b0, "R12", "idle after reset", {cs_n, busy}, 2);

        run_op(8'h06, 24'h0, 5, 0, 0, 0);          // R5 len ignored
        run_op(8'h9F, 24'h0, 3, 0, 0, 0);          // R3 identification
        run_op(8'h05, 24'h0, 2, 0, 0, 0);          // R3 status
        run_op(8'h03, 24'h12AB40, 4, 1, 2, 0);     // R10 auto-poll ignored
        run_op(8'h0B, 24'hFEDC01, 3, 0, 0, 0);     // R1 dummy byte
        run_op(8'h03, 24'h000010, 0, 0, 0, 0);     // R5 zero count
        run_op(8'h5A, 24'h0, 1, 0, 0, 0);          // R7 unknown
        run_op(8'h02, 24'h001000, 257, 0, 0, 0);   // R8 too long
        run_op(8'h02, 24'h002000, 256, 1, 2, 0);   // R8 R9 full page
        run_op(8'hD8, 24'h030000, 0, 1, 3, 0);     // R9 several polls
        run_op(8'hC7, 24'h0, 0, 1, 0, 0);          // R9 single poll
        run_op(8'h20, 24'h004000, 0, 0, 2, 0);     // R9 no poll requested
        run_op(8'h03, 24'h0A0B0C, 4, 0, 0, 1);     // R11 start while busy
        for (int n = 0; n < 30; n++) begin
            logic [7:0] op;
            op = ops[$urandom_range(0, 13)];
            run_op(op, 24'($urandom), (op == 8'h02) ? $urandom_range(1, 12) : $urandom_range(0, 6),
                   1'($urandom_range(0, 1)), $urandom_range(0, 3), 0);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule